// File: doc/BRIEF.md
# Two-Wire Flash Programming Command Engine

This block is the host-side master of a two-wire serial programming link to a flash microcontroller. The host drives a clock line and shares a data line with the target. Each operation is twenty clock pulses: a 4-bit command and then a 16-bit operand. Both fields go out least significant bit first. The data line is split into an output, an output enable and an input, and a pad outside the block combines them.

A user-side controller loads a command, an operand and a hold length, then pulses `start`. The engine raises `busy` and runs the clock pulses. It drops `busy` in the cycle where it pulses `done`. Three cases need special handling. A table read with post-increment (code 4'b1001) releases the data line for its last eight clocks and collects the byte the target returns. A programming-start command (code 4'b1111 by default) keeps the fourth clock high for the write or erase time. Every other code, such as a table write carrying the bulk-erase payload 0x0180, is sent as plain data.

The clock high time and low time are counts of system clock cycles. Host data changes only when the clock rises, so the high time is the setup before the falling edge, where the target samples, and the low time is the hold after it.

Top module: `tw_prog_master`

## Requirements
- R1: After reset, `sclk`=0, `sdat_oe`=1, `sdat_o`=0, `busy`=0, `done`=0 and `rdata`=0.
- R2: An accepted operation produces exactly 20 clock pulses. Each high phase lasts T_HIGH cycles and each low phase lasts T_LOW cycles, except for the case in R6.
- R3: Clocks 1 to 4 carry `cmd[0]` to `cmd[3]` and clocks 5 to 20 carry `operand[0]` to `operand[15]`. Every 16-bit payload is sent unchanged. `sdat_o` changes only at a rising clock edge, so it is stable at each falling edge.
- R4: For code 4'b1001, clocks 5 to 12 are driven with `operand[7:0]`. `sdat_oe` goes low at the rise of clock 13 and stays low until `done`. For every other code, `sdat_oe` stays high for the whole operation.
- R5: For code 4'b1001, `sdat_i` is sampled at the falling edges of clocks 13 to 20. The bit from clock 13 lands in `rdata[0]` and the bit from clock 20 in `rdata[7]`. `rdata` is valid while `done` is high. Any other code leaves `rdata` at 0.
- R6: For code PROG_CODE (default 4'b1111), the high phase of clock 4 lasts T_HIGH + `hold_cycles` cycles.
- R7: `done` is a one-cycle pulse in the cycle after the last low phase. `busy` is high from the cycle after `start` is accepted until that cycle, and is low while `done` is high.
- R8: A `start` that arrives while `busy` is high has no effect. The running operation keeps its bits and its 20 pulses, and no second operation follows it.
- R9: After `done`, `sclk` stays low and `sdat_oe` is high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| cmd | input | 4 | Command code, sampled at start |
| operand | input | 16 | Operand payload, sampled at start |
| hold_cycles | input | 24 | Extra high time on clock 4 of a programming start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by a table read, valid with done |
| sclk | output | 1 | Serial clock to the target |
| sdat_o | output | 1 | Host value for the data line |
| sdat_oe | output | 1 | Host drives the data line when high |
| sdat_i | input | 1 | Data line value seen from the target |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a running operation. It must leave no trace in the bits on the line or in the pulse count. The bench raises `start` with a different command partway through an operation. It then checks every bit and pulse of that operation and confirms that the clock stays low afterwards. A bench model of the target returns a known byte in time for each read falling edge, and the bench measures the widened fourth-clock high phase in cycles. Random commands, payloads and hold lengths come from a seeded generator, mixed with directed cases: a zero hold, a long hold and the bulk-erase payload.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int CMD_BITS   = 4;
    localparam int OPD_BITS   = 16;
    localparam int RD_BITS    = 8;
    localparam int FRAME_BITS = CMD_BITS + OPD_BITS;
    localparam int RD_FIRST   = FRAME_BITS - RD_BITS;
    localparam int HOLD_CLK   = CMD_BITS - 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [CMD_BITS-1:0] CODE_TBL_READ = 4'b1001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [OPD_BITS-1:0] operand;
        logic [CMD_BITS-1:0] cmd;
    } frame_t;

    function automatic logic is_table_read(input logic [CMD_BITS-1:0] c);
        return c == CODE_TBL_READ;
    endfunction
endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    // a phase of zero length would never expire
    assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0))
        else $error("phase length zero");

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1))
        else $error("phase counter skipped");
endmodule

// File: rtl/tw_bit_shifter.sv
module tw_bit_shifter
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  frame_t           frame_in,
    input  logic             rise,
    input  logic [IDX_W-1:0] rise_idx,
    input  logic             capture,
    input  logic             sdat_i,
    output logic             sdat_o,
    output logic [RD_BITS-1:0] rdata
);
    frame_t frame_q;
    logic [FRAME_BITS-1:0] frame_bits;

    assign frame_bits = frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            sdat_o  <= 1'b0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                frame_q <= frame_in;
                sdat_o  <= frame_in.cmd[0];
                rdata   <= '0;
            end else if (rise) begin
                sdat_o <= frame_bits[rise_idx];
            end
            if (capture) begin
                rdata <= {sdat_i, rdata[RD_BITS-1:1]};
            end
        end
    end

    assert_rise_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        rise |-> (rise_idx < IDX_W'(FRAME_BITS) && rise_idx != '0))
        else $error("bit index outside frame");

    assert_no_drive_and_capture_R5: assert property (@(posedge clk) disable iff (rst)
        !(capture && accept))
        else $error("capture during accept");
endmodule

// File: rtl/tw_op_sequencer.sv
module tw_op_sequencer
    import tw_pkg::*;
#(
    parameter int              T_HIGH    = 3,
    parameter int              T_LOW     = 2,
    parameter int              HOLD_W    = 24,
    parameter logic [CMD_BITS-1:0] PROG_CODE = 4'b1111,
    localparam int             CNT_W     = HOLD_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic [HOLD_W-1:0]   hold,
    input  logic                tmr_last,
    output logic                tmr_load,
    output logic [CNT_W-1:0]    tmr_len,
    output logic                accept,
    output logic                rise,
    output logic [IDX_W-1:0]    rise_idx,
    output logic                capture,
    output logic                sclk,
    output logic                oe,
    output logic                busy,
    output logic                done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] RD_IDX   = IDX_W'(RD_FIRST);
    localparam logic [IDX_W-1:0] HOLD_IDX = IDX_W'(HOLD_CLK);

    seq_state_t          state;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    nxt_idx;
    logic                rd_q;
    logic                pg_q;
    logic [HOLD_W-1:0]   hold_q;
    logic                fall;

    assign nxt_idx  = idx + 1'b1;
    assign accept   = (state == ST_IDLE) && start;
    assign fall     = (state == ST_HIGH) && tmr_last;
    assign rise     = (state == ST_LOW) && tmr_last && (idx != LAST_IDX);
    assign rise_idx = nxt_idx;
    assign capture  = fall && rd_q && (idx >= RD_IDX);

    always_comb begin
        tmr_load = accept || fall || rise;
        tmr_len  = CNT_W'(T_HIGH);
        if (fall) begin
            tmr_len = CNT_W'(T_LOW);
        end else if (rise && pg_q && nxt_idx == HOLD_IDX) begin
            tmr_len = CNT_W'(T_HIGH) + {1'b0, hold_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            rd_q   <= 1'b0;
            pg_q   <= 1'b0;
            hold_q <= '0;
            sclk   <= 1'b0;
            oe     <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_HIGH;
                        idx    <= '0;
                        rd_q   <= is_table_read(cmd);
                        pg_q   <= (cmd == PROG_CODE);
                        hold_q <= hold;
                        sclk   <= 1'b1;
                        busy   <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tmr_last) begin
                        state <= ST_LOW;
                        sclk  <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (tmr_last) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_IDLE;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            oe    <= 1'b1;
                        end else begin
                            state <= ST_HIGH;
                            idx   <= nxt_idx;
                            sclk  <= 1'b1;
                            if (rd_q && nxt_idx == RD_IDX) begin
                                oe <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_busy_done_apart_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done))
        else $error("busy and done together");

    assert_release_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !oe) |=> (!oe || done))
        else $error("data line retaken before done");

    assert_idle_clock_low_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (!sclk && oe))
        else $error("clock or drive active while idle");

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(rd_q) && $stable(pg_q) && $stable(hold_q)))
        else $error("operation changed while busy");
endmodule

// File: rtl/tw_prog_master.sv
module tw_prog_master
    import tw_pkg::*;
#(
    parameter int                  T_HIGH    = 3,
    parameter int                  T_LOW     = 2,
    parameter int                  HOLD_W    = 24,
    parameter logic [CMD_BITS-1:0] PROG_CODE = 4'b1111
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic [OPD_BITS-1:0] operand,
    input  logic [HOLD_W-1:0]   hold_cycles,
    output logic                busy,
    output logic                done,
    output logic [RD_BITS-1:0]  rdata,
    output logic                sclk,
    output logic                sdat_o,
    output logic                sdat_oe,
    input  logic                sdat_i
);
    localparam int CNT_W = HOLD_W + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;
    logic             accept;
    logic             rise;
    logic [IDX_W-1:0] rise_idx;
    logic             capture;
    frame_t           frame_in;

    assign frame_in.cmd     = cmd;
    assign frame_in.operand = operand;

    tw_op_sequencer #(
        .T_HIGH    (T_HIGH),
        .T_LOW     (T_LOW),
        .HOLD_W    (HOLD_W),
        .PROG_CODE (PROG_CODE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (cmd),
        .hold     (hold_cycles),
        .tmr_last (tmr_last),
        .tmr_load (tmr_load),
        .tmr_len  (tmr_len),
        .accept   (accept),
        .rise     (rise),
        .rise_idx (rise_idx),
        .capture  (capture),
        .sclk     (sclk),
        .oe       (sdat_oe),
        .busy     (busy),
        .done     (done)
    );

    tw_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .last (tmr_last)
    );

    tw_bit_shifter u_shf (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .frame_in (frame_in),
        .rise     (rise),
        .rise_idx (rise_idx),
        .capture  (capture),
        .sdat_i   (sdat_i),
        .sdat_o   (sdat_o),
        .rdata    (rdata)
    );

    assert_data_stable_high_R3: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdat_o))
        else $error("data moved while clock high");

    assert_data_stable_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!sclk && busy && $past(busy)) |-> $stable(sdat_o))
        else $error("data moved while clock low");
endmodule

// File: tb/sim_tw_prog_master.sv
module sim_tw_prog_master;
    localparam int T_HIGH = 3;
    localparam int T_LOW  = 2;
    localparam logic [3:0] C_READ = 4'b1001;
    localparam logic [3:0] C_PROG = 4'b1111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cmd = '0;
    logic [15:0] operand = '0;
    logic [23:0] hold_cycles = '0;
    logic        busy, done, sclk, sdat_o, sdat_oe;
    logic [7:0]  rdata;
    logic        sdat_i = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    tw_prog_master #(.T_HIGH(T_HIGH), .T_LOW(T_LOW), .HOLD_W(24), .PROG_CODE(C_PROG)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .operand(operand),
        .hold_cycles(hold_cycles), .busy(busy), .done(done), .rdata(rdata),
        .sclk(sclk), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic int exp_high(input logic [3:0] c, input int k, input int hd);
        return (c == C_PROG && k == 3) ? T_HIGH + hd : T_HIGH;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [3:0] c, input logic [7:0] b);
        return (c == C_READ) ? b : 8'h00;
    endfunction

    task automatic run_op(input logic [3:0] c, input logic [15:0] opd, input int hd,
                          input logic [7:0] tbyte, input bit poke);
        logic [19:0] got_bits;
        logic [19:0] exp_bits;
        logic [19:0] mask;
        int nclk, hi_len, lo_len, cyc, hi_bad, lo_bad, oe_bad, busy_bad;
        logic prev, s;
        got_bits = '0;
        nclk = 0; hi_len = 0; lo_len = 0; cyc = 0;
        hi_bad = 0; lo_bad = 0; oe_bad = 0; busy_bad = 0;
        prev = 1'b0;
        @(negedge clk);
        cmd = c; operand = opd; hold_cycles = 24'(hd); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd = $urandom_range(15, 0); operand = $urandom;
        while (!done && cyc < 4000 + hd) begin
            s = sclk;
            if (busy !== 1'b1) busy_bad++;
            if (poke && cyc == 7) begin
                start = 1'b1; cmd = C_READ; operand = 16'hFFFF;
            end else begin
                start = 1'b0;
            end
            if (s && !prev) begin
                if (nclk >= 1 && lo_len != T_LOW) lo_bad++;
                hi_len = 0;
                if (c == C_READ && nclk >= 12 && nclk < 20) sdat_i = tbyte[nclk-12];
                else sdat_i = 1'($urandom);
            end
            if (s) hi_len++;
            if (!s && prev) begin
                if (hi_len != exp_high(c, nclk, hd)) hi_bad++;
                if (nclk < 20) got_bits[nclk] = sdat_o;
                if (sdat_oe !== ((c == C_READ && nclk >= 12) ? 1'b0 : 1'b1)) oe_bad++;
                nclk++;
                lo_len = 0;
            end
            if (!s) lo_len++;
            prev = s;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (lo_len != T_LOW) lo_bad++;
        exp_bits = {opd, c};
        mask = (c == C_READ) ? 20'h00FFF : 20'hFFFFF;
        chk(done === 1'b1, "R7", "done reached", done, 1);
        chk(busy === 1'b0, "R7", "busy low with done", busy, 0);
        chk(nclk == 20, "R2", "clock pulses", nclk, 20);
        chk(hi_bad == 0 && lo_bad == 0, "R2", "phase widths bad count", hi_bad + lo_bad, 0);
        if (c == C_PROG) chk(hi_bad == 0, "R6", "fourth clock hold", hi_bad, 0);
        chk(busy_bad == 0, "R7", "busy dropped early", busy_bad, 0);
        chk((got_bits & mask) == (exp_bits & mask), "R3", "bits on line",
            got_bits & mask, exp_bits & mask);
        chk(oe_bad == 0, "R4", "drive enable errors", oe_bad, 0);
        chk(rdata == exp_rdata(c, tbyte), "R5", "returned byte", rdata, exp_rdata(c, tbyte));
        chk(sdat_oe === 1'b1 && sclk === 1'b0, "R9", "idle at done", {sclk, sdat_oe}, 2'b01);
        if (poke) chk(nclk == 20 && (got_bits & mask) == (exp_bits & mask), "R8",
            "op altered by late start", got_bits, exp_bits);
        @(negedge clk);
        chk(done === 1'b0, "R7", "done single cycle", done, 0);
        if (poke) begin
            for (int i = 0; i < 8; i++) begin
                if (sclk !== 1'b0 || busy !== 1'b0) begin
                    chk(1'b0, "R8", "second operation started", busy, 0);
                    break;
                end
                @(negedge clk);
            end
        end
        chk(sclk === 1'b0 && sdat_oe === 1'b1, "R9", "clock idles low", sclk, 0);
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk === 1'b0 && sdat_oe === 1'b1 && sdat_o === 1'b0, "R1", "line reset",
            {sclk, sdat_oe, sdat_o}, 3'b010);
        chk(busy === 1'b0 && done === 1'b0 && rdata === 8'h00, "R1", "status reset",
            {busy, done, rdata}, 0);

        run_op(C_READ, 16'h0000, 0, 8'hA5, 1'b0);
        run_op(C_READ, 16'h00C3, 5, 8'h01, 1'b0);
        run_op(C_READ, 16'h5A00, 0, 8'h80, 1'b0);
        run_op(4'b1100, 16'h0180, 0, 8'h3C, 1'b0);
        run_op(C_PROG, 16'h0000, 0, 8'h00, 1'b0);
        run_op(C_PROG, 16'h0000, 1000, 8'h00, 1'b0);
        run_op(4'b0000, 16'hFFFF, 7, 8'hFF, 1'b1);
        run_op(C_READ, 16'h1234, 0, 8'h6E, 1'b1);

        for (int n = 0; n < 40; n++) begin
            logic [3:0] c;
            int pick;
            pick = $urandom_range(3, 0);
            c = (pick == 0) ? C_READ : (pick == 1) ? C_PROG : 4'($urandom);
            run_op(c, 16'($urandom), $urandom_range(60, 0), 8'($urandom), (n % 9) == 4);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule